// File: doc/BRIEF.md
# MDIO Management Master

This block is a host-programmed master for the two-wire PHY management bus. It derives the management clock from the system clock through a programmable divider. On command it runs one read or one write to a register inside a PHY, using the classic 32-bit-preamble frame. Software reaches it through a small synchronous register bus with four word locations: configuration, command, write data and read data. The bidirectional data pin is handled as separate output, output-enable and input signals, so the pad cell sits outside the block.

Software first sets the divider and the enable bit. It then polls the ready flag in the command register. For a write it loads the write-data register before issuing the command. It issues a command by setting the initiate bit together with the addresses and the operation, and polls ready again until the transfer ends. After a read, the returned value is in the read-data register.

Top module: `mdio_master`

## Requirements
- R1: After reset, the configuration register reads 0, the management clock `mdc` is low, `mdio_oe` is low and the ready flag (command bit 7) reads 1.
- R2: While enabled, `mdc` has a period of exactly 2*(1+N) system clock cycles, where N is configuration bits 5:0. Configuration bit 6 is the enable.
- R3: While the enable bit is clear, `mdc` stays low and `mdio_oe` stays low. Writing 0 to the configuration register stops `mdc` and aborts any transfer in progress, and ready returns to 1.
- R4: A write (command bits 15:14 = 01) sends 64 bits, all driven and MSB first: 32 ones, 01, 01, PHY address (command bits 28:24), register address (command bits 20:16), 10, then the 16 bits from the write-data register (address 2, bits 15:0).
- R5: A read (command bits 15:14 = 10) drives 32 ones, 01, 10 and both addresses. It then holds `mdio_oe` low for the two turnaround bits and the 16 data bits.
- R6: After a read, the read-data register (address 3) holds in bits 15:0 the 16 bits sampled on `mdio_i` MSB first, and reads 0 in bits 31:16.
- R7: Ready reads 0 from the cycle after an accepted initiate until the frame ends, and then reads 1.
- R8: An initiate (command bit 11) written while ready is 0 or while the block is disabled is ignored. It does not alter the frame in flight and does not start one.
- R9: The command register reads back the addresses and operation of the last accepted command. The initiate bit always reads 0.
- R10: `mdio_o` and `mdio_oe` change only on the system clock edge where `mdc` falls, or when the block is disabled. `mdio_i` is sampled on the edge where `mdc` rises.
- R11: An initiate with an operation code other than 01 or 10 is ignored and ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 config, 1 command, 2 write data, 3 read data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable |
| mdio_i | input | 1 | Data pin input value |

## Verification
The hardest case to reach is a second initiate that lands while a frame is partly shifted out. An initiate while busy must leave the frame in flight untouched. The stimulus issues one command, waits a random number of cycles inside the frame, and writes a conflicting command with different addresses. It then compares the whole recorded frame with the first command's expected bits. A second hard case is disabling the block in the middle of a frame, which is reached by clearing the configuration after a partial transfer. A bench model of the PHY records the pin on every rising `mdc` edge and returns random data in the read phase. Random addresses, data and small dividers are mixed with directed divider extremes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PREAMBLE_BITS = 32;

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mdio_opc_e;

  typedef enum logic [1:0] {
    RA_CFG   = 2'd0,
    RA_CMD   = 2'd1,
    RA_WDATA = 2'd2,
    RA_RDATA = 2'd3
  } reg_addr_e;

  localparam int CMD_PHY_LSB = 24;
  localparam int CMD_REG_LSB = 16;
  localparam int CMD_OP_LSB  = 14;
  localparam int CMD_GO_BIT  = 11;
  localparam int CMD_RDY_BIT = 7;
  localparam int CFG_EN_BIT  = 6;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;

  always_comb begin
    cnt_d    = cnt_q;
    mdc_d    = mdc_q;
    rise_stb = 1'b0;
    fall_stb = 1'b0;
    if (!en) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (cnt_q >= div) begin
      cnt_d    = '0;
      mdc_d    = ~mdc_q;
      rise_stb = ~mdc_q;
      fall_stb = mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

  assert_mdc_idle_when_off_R3: assert property (
    @(posedge clk) disable iff (!rst_n) !en |=> !mdc_q);
  assert_rise_sets_mdc_R2: assert property (
    @(posedge clk) disable iff (!rst_n) rise_stb |=> mdc_q);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic              op_read,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FRAME_BITS = PREAMBLE_BITS + 6 + 2 * ADDR_W + DATA_W;
  localparam int HDR_BITS   = FRAME_BITS - DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int DRV_BITS   = HDR_BITS - 2;

  logic [FRAME_BITS-1:0] sh_q, sh_d, msk_q, msk_d, frame, mask;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  busy_q, busy_d, rd_q, rd_d, o_q, o_d, oe_q, oe_d;
  logic [DATA_W-1:0]     cap_q, cap_d, rdat_q, rdat_d;

  always_comb begin
    frame = {{PREAMBLE_BITS{1'b1}}, 2'b01,
             op_read ? OPC_READ : OPC_WRITE,
             phy, regad,
             op_read ? 2'b11 : 2'b10,
             op_read ? {DATA_W{1'b1}} : wdata};
    mask  = op_read ? {{DRV_BITS{1'b1}}, {(FRAME_BITS-DRV_BITS){1'b0}}}
                    : {FRAME_BITS{1'b1}};
  end

  always_comb begin
    sh_d   = sh_q;
    msk_d  = msk_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    o_d    = o_q;
    oe_d   = oe_q;
    cap_d  = cap_q;
    rdat_d = rdat_q;
    if (!en) begin
      busy_d = 1'b0;
      oe_d   = 1'b0;
      o_d    = 1'b1;
    end else if (start && !busy_q) begin
      sh_d   = frame;
      msk_d  = mask;
      cnt_d  = '0;
      busy_d = 1'b1;
      rd_d   = op_read;
    end else if (busy_q) begin
      if (fall_stb) begin
        if (cnt_q == CNT_W'(FRAME_BITS)) begin
          busy_d = 1'b0;
          oe_d   = 1'b0;
          o_d    = 1'b1;
          if (rd_q) rdat_d = cap_q;
        end else begin
          o_d   = sh_q[FRAME_BITS-1];
          oe_d  = msk_q[FRAME_BITS-1];
          sh_d  = sh_q << 1;
          msk_d = msk_q << 1;
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (rise_stb && rd_q && cnt_q > CNT_W'(HDR_BITS))
        cap_d = {cap_q[DATA_W-2:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      msk_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      o_q    <= 1'b1;
      oe_q   <= 1'b0;
      cap_q  <= '0;
      rdat_q <= '0;
    end else begin
      sh_q   <= sh_d;
      msk_q  <= msk_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
      o_q    <= o_d;
      oe_q   <= oe_d;
      cap_q  <= cap_d;
      rdat_q <= rdat_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign rd_data = rdat_q;

  assert_pin_moves_on_fall_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    (!$stable(o_q) || !$stable(oe_q)) |-> ($past(fall_stb) || !$past(en)));
  assert_read_releases_line_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && cnt_q >= CNT_W'(DRV_BITS + 1)) |-> !oe_q);
  assert_idle_not_driving_R3: assert property (
    @(posedge clk) disable iff (!rst_n) $fell(busy_q) |-> !oe_q);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic              en,
  output logic [DIV_W-1:0]  div,
  output logic              start,
  output logic              op_read,
  output logic [ADDR_W-1:0] phy,
  output logic [ADDR_W-1:0] regad,
  output logic [DATA_W-1:0] wd
);
  logic              en_q, en_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [ADDR_W-1:0] phy_q, phy_d, reg_q, reg_d;
  logic [1:0]        op_q, op_d, bus_op;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              op_ok;

  assign bus_op  = wdata[CMD_OP_LSB +: 2];
  assign op_ok   = (bus_op == OPC_READ) || (bus_op == OPC_WRITE);
  assign start   = wr && (addr == RA_CMD) && wdata[CMD_GO_BIT] && en_q && !busy && op_ok;
  assign op_read = (bus_op == OPC_READ);
  assign phy     = wdata[CMD_PHY_LSB +: ADDR_W];
  assign regad   = wdata[CMD_REG_LSB +: ADDR_W];

  always_comb begin
    en_d  = en_q;
    div_d = div_q;
    phy_d = phy_q;
    reg_d = reg_q;
    op_d  = op_q;
    wd_d  = wd_q;
    if (wr && addr == RA_CFG) begin
      en_d  = wdata[CFG_EN_BIT];
      div_d = wdata[DIV_W-1:0];
    end
    if (wr && addr == RA_WDATA) wd_d = wdata[DATA_W-1:0];
    if (start) begin
      phy_d = phy;
      reg_d = regad;
      op_d  = bus_op;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= '0;
      phy_q <= '0;
      reg_q <= '0;
      op_q  <= '0;
      wd_q  <= '0;
    end else begin
      en_q  <= en_d;
      div_q <= div_d;
      phy_q <= phy_d;
      reg_q <= reg_d;
      op_q  <= op_d;
      wd_q  <= wd_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CFG: begin
        rdata[CFG_EN_BIT]  = en_q;
        rdata[DIV_W-1:0]   = div_q;
      end
      RA_CMD: begin
        rdata[CMD_PHY_LSB +: ADDR_W] = phy_q;
        rdata[CMD_REG_LSB +: ADDR_W] = reg_q;
        rdata[CMD_OP_LSB +: 2]       = op_q;
        rdata[CMD_RDY_BIT]           = ~busy;
      end
      RA_WDATA: rdata[DATA_W-1:0] = wd_q;
      default:  rdata[DATA_W-1:0] = rd_data;
    endcase
  end

  assign en  = en_q;
  assign div = div_q;
  assign wd  = wd_q;

  assert_busy_needs_command_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr && addr == RA_CMD && en_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic              rst_meta_n, rst_sync_n;
  logic              en, start, op_read, busy, rise_stb, fall_stb;
  logic [DIV_W-1:0]  div;
  logic [ADDR_W-1:0] phy, regad;
  logic [DATA_W-1:0] wd, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  mdio_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) regs_i (
    .clk(clk), .rst_n(rst_sync_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .rd_data(rd_data), .en(en), .div(div),
    .start(start), .op_read(op_read), .phy(phy), .regad(regad), .wd(wd));

  mdio_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .div(div),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb));

  mdio_frame_eng #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .start(start), .op_read(op_read),
    .phy(phy), .regad(regad), .wdata(wd), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  logic        clk, rst_n, reg_wr, mdio_i;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdc, mdio_o, mdio_oe;

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [63:0] rec_o, rec_oe;
  logic [15:0] resp;
  int  idx;
  bit  armed, started;

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run exceeded cycle limit (actual %0d expected <150000)", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // PHY model: present data before each rising mdc, record pin on rising mdc
  always @(negedge mdc) begin
    if (armed) started = 1'b1;
    mdio_i = (idx >= 48 && idx < 64) ? resp[63 - idx] : 1'b1;
  end
  always @(posedge mdc) begin
    if (started && idx < 64) begin
      rec_o[63 - idx]  = mdio_o;
      rec_oe[63 - idx] = mdio_oe;
      idx++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cmd_word(input logic [4:0] p, input logic [4:0] r,
                                           input logic [1:0] op, input bit go);
    return {3'b0, p, 3'b0, r, op, 2'b0, go, 11'b0};
  endfunction

  function automatic logic [63:0] exp_frame(input logic [4:0] p, input logic [4:0] r,
                                            input bit rd, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, p, r, 2'b10, d};
  endfunction

  function automatic logic [63:0] exp_oe(input bit rd);
    return rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
  endfunction

  task automatic wait_ready(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      rd_reg(2'd1, v);
      if (v[7]) begin ok = 1'b1; break; end
    end
  endtask

  // Run one transaction; optionally inject a conflicting command mid-frame.
  task automatic run_txn(input logic [4:0] p, input logic [4:0] r, input bit rd,
                         input logic [15:0] d, input bit inject, input int inj_wait);
    logic [31:0] v;
    logic [63:0] mask;
    bit ok;
    idx = 0; started = 1'b0; armed = 1'b0; rec_o = '0; rec_oe = '0;
    resp = d;
    if (!rd) wr_reg(2'd2, {16'hA5A5, d});
    wr_reg(2'd1, cmd_word(p, r, rd ? 2'b10 : 2'b01, 1'b1));
    armed = 1'b1;
    rd_reg(2'd1, v);
    chk(v[7] == 1'b0, "R7 ready low after initiate", {63'b0, v[7]}, 64'd0);
    if (inject) begin
      repeat (inj_wait) @(negedge clk);
      wr_reg(2'd1, cmd_word(~p, ~r, rd ? 2'b01 : 2'b10, 1'b1));
    end
    wait_ready(ok);
    armed = 1'b0;
    chk(ok, "R7 ready returns high", {63'b0, ok}, 64'd1);
    mask = exp_oe(rd);
    chk(rec_oe == mask && idx == 64, rd ? "R5 read drive enable" : "R4 write drive enable",
        rec_oe, mask);
    chk((rec_o & mask) == (exp_frame(p, r, rd, d) & mask),
        inject ? "R8 frame unchanged by busy initiate" : (rd ? "R5 read header" : "R4 write frame"),
        rec_o & mask, exp_frame(p, r, rd, d) & mask);
    if (rd) begin
      rd_reg(2'd3, v);
      chk(v == {16'b0, d}, "R6 read data register", {32'b0, v}, {48'b0, d});
    end
    rd_reg(2'd1, v);
    chk(v == (cmd_word(p, r, rd ? 2'b10 : 2'b01, 1'b0) | 32'h80), "R9 command readback",
        {32'b0, v}, {32'b0, cmd_word(p, r, rd ? 2'b10 : 2'b01, 1'b0) | 32'h80});
  endtask

  task automatic period_check(input logic [5:0] n);
    realtime t0, t1;
    int per;
    wr_reg(2'd0, {25'b0, 1'b1, n});
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    per = int'((t1 - t0) / 8.0);
    chk(per == 2 * (n + 1), "R2 mdc period", 64'(per), 64'(2 * (n + 1)));
  endtask

  initial begin
    logic [31:0] v;
    bit ok, moved;
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; mdio_i = 1'b1;
    idx = 0; armed = 1'b0; started = 1'b0; resp = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_reg(2'd0, v);
    chk(v == 32'd0, "R1 config after reset", {32'b0, v}, 64'd0);
    rd_reg(2'd1, v);
    chk(v[7] == 1'b1, "R1 ready after reset", {63'b0, v[7]}, 64'd1);
    chk(!mdc && !mdio_oe, "R1 mdc and oe low after reset", {62'b0, mdc, mdio_oe}, 64'd0);

    // R3 and R8: disabled block ignores initiate, mdc stays low
    wr_reg(2'd1, cmd_word(5'd3, 5'd4, 2'b10, 1'b1));
    moved = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (mdc || mdio_oe) moved = 1'b1;
    end
    chk(!moved, "R3 mdc idle while disabled", {63'b0, moved}, 64'd0);
    rd_reg(2'd1, v);
    chk(v[7] == 1'b1, "R8 initiate ignored while disabled", {63'b0, v[7]}, 64'd1);

    // R2 divider extremes and middle
    period_check(6'd0);
    period_check(6'd1);
    period_check(6'd5);
    period_check(6'd63);

    // R11 invalid operation codes ignored
    wr_reg(2'd0, 32'h41);
    wr_reg(2'd1, cmd_word(5'd1, 5'd1, 2'b00, 1'b1));
    rd_reg(2'd1, v);
    chk(v[7] == 1'b1, "R11 op 00 ignored", {63'b0, v[7]}, 64'd1);
    wr_reg(2'd1, cmd_word(5'd1, 5'd1, 2'b11, 1'b1));
    rd_reg(2'd1, v);
    chk(v[7] == 1'b1, "R11 op 11 ignored", {63'b0, v[7]}, 64'd1);

    // Directed frames: R4 all-ones/zeros, R5 R6
    wr_reg(2'd0, 32'h40);
    run_txn(5'h1F, 5'h00, 1'b0, 16'h0000, 1'b0, 0);
    run_txn(5'h00, 5'h1F, 1'b1, 16'hFFFF, 1'b0, 0);
    run_txn(5'h15, 5'h0A, 1'b1, 16'h8001, 1'b0, 0);

    // R8 conflicting initiate while busy
    wr_reg(2'd0, 32'h41);
    run_txn(5'h0C, 5'h13, 1'b0, 16'hBEEF, 1'b1, 40);
    run_txn(5'h07, 5'h02, 1'b1, 16'h1234, 1'b1, 200);

    // Random mix
    for (int k = 0; k < 16; k++) begin
      logic [5:0] n;
      n = 6'($urandom_range(0, 3));
      wr_reg(2'd0, {25'b0, 1'b1, n});
      run_txn(5'($urandom), 5'($urandom), 1'($urandom), 16'($urandom),
              ($urandom_range(0, 3) == 0), $urandom_range(5, 120));
    end

    // R3 abort mid-frame by writing 0 to config
    wr_reg(2'd0, 32'h41);
    wr_reg(2'd1, cmd_word(5'd2, 5'd9, 2'b01, 1'b1));
    repeat (60) @(negedge clk);
    wr_reg(2'd0, 32'h0);
    rd_reg(2'd1, v);
    chk(v[7] == 1'b1, "R3 ready after abort", {63'b0, v[7]}, 64'd1);
    moved = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (mdc || mdio_oe) moved = 1'b1;
    end
    chk(!moved, "R3 mdc and oe stop after disable", {63'b0, moved}, 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule